// File: doc/BRIEF.md
# Audio Mute and Standby Sequencer

This block decides, every system-clock cycle, whether an audio DAC core is held in reset, parked in standby, muted, or allowed to play. It watches five things: a supply-good flag from an external comparator, an active-low soft-mute pin, one strobe per audio frame carrying the left and right sample words, and the three audio clocks (master, bit and frame). From these it drives a reset output, an analog-mute output, a standby output and a three-bit state code.

Long delays are counted in ticks from a shared divider of the system clock, so that one parameter maps a tick to a millisecond in silicon and a much shorter interval in simulation. Each audio clock is synchronised into the system domain and declared halted when it shows no edge for a programmable number of system cycles. The system clock must therefore run at more than twice the fastest monitored clock. Each condition is held in its own flag, and a fixed priority picks the one state that is reported. The state is registered, so every output changes one cycle after the flag that causes it.

Top module: `dac_mute_seq`

## Requirements
- R1: While the synchronised supply-good flag is low, the state code is 5 (reset), with dac_rst_o=1, amute_o=1 and stby_o=0.
- R2: After supply-good rises, reset stays asserted for POR_TICKS ticks of TICK_DIV system cycles each. The tolerance is one tick plus the synchroniser and register latency.
- R3: Once ZERO_RUN consecutive frame strobes each carry zero on both channels, the state becomes code 1 (zero-data mute) with amute_o=1. A shorter run does not mute.
- R4: A frame strobe with a non-zero sample on either channel clears the zero run and releases the zero-data mute on the next cycle.
- R5: A low soft-mute pin gives state code 2. If the pin stays low for UV_TICKS ticks, the state becomes code 3 (undervoltage protection) until the pin goes high.
- R6: A monitored clock with no edge for HALT_CYC system cycles forces standby, state code 4 with stby_o=1. A shorter gap has no effect.
- R7: Standby is left only when no clock is halted and RESUME_FRAMES frame-clock rising edges have occurred, each closing a frame in which the master and bit clocks both rose.
- R8: When several conditions are active, the reported state follows this priority, highest first: reset, standby, undervoltage, soft mute, zero-data mute, play.
- R9: In play (code 0), dac_rst_o, amute_o and stby_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| supply_ok_i | input | 1 | Supply-good comparator flag, asynchronous |
| smute_n_i | input | 1 | Active-low soft-mute pin, asynchronous |
| mclk_i | input | 1 | Master audio clock, monitored for activity |
| bclk_i | input | 1 | Bit clock, monitored for activity |
| lrclk_i | input | 1 | Frame clock, monitored for activity and frame counting |
| frame_stb_i | input | 1 | One-cycle strobe marking a received frame |
| smp_l_i | input | DW | Left sample of the frame, valid with the strobe |
| smp_r_i | input | DW | Right sample of the frame, valid with the strobe |
| dac_rst_o | output | 1 | Reset to the DAC core, active high |
| amute_o | output | 1 | Analog mute, high in every state except play |
| stby_o | output | 1 | Standby request, high in state code 4 |
| state_o | output | 3 | Current state code (0 play … 5 reset) |

## Verification
The hardest situation to reach is a stack of conditions, such as a clock halting while the undervoltage timer has already expired over a standing zero-data mute. Priority, and what happens as each layer is peeled away, can only be seen there. The stimulus builds this stack on purpose. It completes a zero run, holds soft mute past the undervoltage time, stops the bit clock, and then releases the pin and the clock in turn, checking the state at each step. Resume counting is tested by checking just before and well after the required number of frames. Seeded random frame streams, in which mostly-zero samples are mixed with sparse non-zero words on either channel, drive the zero-run counter against a bench model.

// File: rtl/dac_mute_pkg.sv
package dac_mute_pkg;
   typedef enum logic [2:0] {
      ST_PLAY  = 3'd0,
      ST_ZMUTE = 3'd1,
      ST_SMUTE = 3'd2,
      ST_UVP   = 3'd3,
      ST_STBY  = 3'd4,
      ST_RST   = 3'd5
   } mute_state_t;

   localparam int unsigned NUM_CLK_MON = 3;

   function automatic int unsigned cnt_w(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/msq_tick.sv
module msq_tick #(
   parameter int unsigned DIV = 50000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (DIV <= 1) begin : g_pass
         logic unused_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) unused_q <= 1'b0;
            else        unused_q <= 1'b1;
         assign tick_o = unused_q | 1'b1;
      end else begin : g_div
         localparam int unsigned CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;
         logic          wrap;
         assign wrap = (cnt_q == CW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)    cnt_q <= '0;
            else if (wrap) cnt_q <= '0;
            else           cnt_q <= cnt_q + 1'b1;
         assign tick_o = wrap;
      end
   endgenerate
endmodule

// File: rtl/msq_timer.sv
module msq_timer #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic run_i,
   output logic done_o
);
   localparam int unsigned CW = dac_mute_pkg::cnt_w(LIMIT);
   logic [CW-1:0] cnt_q;

   generate
      if (LIMIT < 1) begin : g_bad
         $error("msq_timer: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                cnt_q <= '0;
      else if (!run_i)                           cnt_q <= '0;
      else if (tick_i && cnt_q != CW'(LIMIT))    cnt_q <= cnt_q + 1'b1;

   assign done_o = run_i && (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/msq_act_mon.sv
module msq_act_mon #(
   parameter int unsigned HALT_CYC    = 4096,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mon_i,
   output logic rise_o,
   output logic halted_o
);
   localparam int unsigned CW = dac_mute_pkg::cnt_w(HALT_CYC);
   logic [SYNC_STAGES-1:0] sh_q;
   logic                   prev_q;
   logic                   lvl;
   logic                   edge_seen;
   logic [CW-1:0]          gap_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[SYNC_STAGES-2:0], mon_i};
         prev_q <= lvl;
      end

   assign lvl       = sh_q[SYNC_STAGES-1];
   assign edge_seen = lvl ^ prev_q;
   assign rise_o    = lvl & ~prev_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                        gap_q <= '0;
      else if (edge_seen)                gap_q <= '0;
      else if (gap_q != CW'(HALT_CYC))   gap_q <= gap_q + 1'b1;

   assign halted_o = (gap_q == CW'(HALT_CYC));
endmodule

// File: rtl/msq_zero_run.sv
module msq_zero_run #(
   parameter int unsigned DW  = 24,
   parameter int unsigned RUN = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb_i,
   input  logic [DW-1:0] l_i,
   input  logic [DW-1:0] r_i,
   output logic          zmute_o
);
   localparam int unsigned CW = dac_mute_pkg::cnt_w(RUN);
   logic [CW-1:0] run_q;
   logic          nonzero;

   assign nonzero = (|l_i) | (|r_i);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                          run_q <= '0;
      else if (stb_i && nonzero)           run_q <= '0;
      else if (stb_i && run_q != CW'(RUN)) run_q <= run_q + 1'b1;

   assign zmute_o = (run_q == CW'(RUN));
endmodule

// File: rtl/dac_mute_seq.sv
module dac_mute_seq
   import dac_mute_pkg::*;
#(
   parameter int unsigned DW            = 24,
   parameter int unsigned TICK_DIV      = 50000,
   parameter int unsigned POR_TICKS     = 4,
   parameter int unsigned UV_TICKS      = 6,
   parameter int unsigned ZERO_RUN      = 1024,
   parameter int unsigned HALT_CYC      = 4096,
   parameter int unsigned RESUME_FRAMES = 4,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          supply_ok_i,
   input  logic          smute_n_i,
   input  logic          mclk_i,
   input  logic          bclk_i,
   input  logic          lrclk_i,
   input  logic          frame_stb_i,
   input  logic [DW-1:0] smp_l_i,
   input  logic [DW-1:0] smp_r_i,
   output logic          dac_rst_o,
   output logic          amute_o,
   output logic          stby_o,
   output logic [2:0]    state_o
);
   localparam int unsigned RCW = cnt_w(RESUME_FRAMES);

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("dac_mute_seq: SYNC_STAGES must be at least 2");
      end
      if (RESUME_FRAMES < 1) begin : g_chk_res
         $error("dac_mute_seq: RESUME_FRAMES must be at least 1");
      end
      if (ZERO_RUN < 1) begin : g_chk_zr
         $error("dac_mute_seq: ZERO_RUN must be at least 1");
      end
   endgenerate

   // input synchronisers for the two level pins
   logic [SYNC_STAGES-1:0] sup_sh_q, sm_sh_q;
   logic                   sup_q, smute_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sup_sh_q <= '0;
         sm_sh_q  <= '0;
      end else begin
         sup_sh_q <= {sup_sh_q[SYNC_STAGES-2:0], supply_ok_i};
         sm_sh_q  <= {sm_sh_q[SYNC_STAGES-2:0], smute_n_i};
      end

   assign sup_q   = sup_sh_q[SYNC_STAGES-1];
   assign smute_q = sm_sh_q[SYNC_STAGES-1];

   // shared time base and the two tick timers
   logic tick, por_done, uv_flag;

   msq_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick_o(tick));

   msq_timer #(.LIMIT(POR_TICKS)) u_por (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(sup_q), .done_o(por_done));

   msq_timer #(.LIMIT(UV_TICKS)) u_uv (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(~smute_q), .done_o(uv_flag));

   // zero-data run
   logic zm_flag;

   msq_zero_run #(.DW(DW), .RUN(ZERO_RUN)) u_zero (
      .clk(clk), .rst_n(rst_n), .stb_i(frame_stb_i),
      .l_i(smp_l_i), .r_i(smp_r_i), .zmute_o(zm_flag));

   // clock activity monitors: bit 0 master, bit 1 bit clock, bit 2 frame clock
   logic [NUM_CLK_MON-1:0] mon_in, rise_v, halt_v;
   logic                   any_halt;

   assign mon_in = {lrclk_i, bclk_i, mclk_i};

   for (genvar g = 0; g < NUM_CLK_MON; g++) begin : g_mon
      msq_act_mon #(.HALT_CYC(HALT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_mon (
         .clk(clk), .rst_n(rst_n), .mon_i(mon_in[g]),
         .rise_o(rise_v[g]), .halted_o(halt_v[g]));
   end

   assign any_halt = |halt_v;

   // standby flag with frame-counted recovery
   logic           stby_q;
   logic [RCW-1:0] res_q;
   logic [1:0]     seen_q;
   logic           lr_rise, good_frame;

   assign lr_rise    = rise_v[NUM_CLK_MON-1];
   assign good_frame = lr_rise && (&seen_q);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         stby_q <= 1'b0;
         res_q  <= '0;
         seen_q <= '0;
      end else begin
         if (lr_rise) seen_q <= '0;
         else         seen_q <= seen_q | rise_v[1:0];

         if (any_halt) begin
            stby_q <= 1'b1;
            res_q  <= '0;
         end else if (stby_q && good_frame) begin
            if (res_q == RCW'(RESUME_FRAMES - 1)) begin
               stby_q <= 1'b0;
               res_q  <= '0;
            end else begin
               res_q <= res_q + 1'b1;
            end
         end
      end

   // priority select and registered state
   mute_state_t st_d, st_q;

   always_comb begin
      if (!por_done)     st_d = ST_RST;
      else if (stby_q)   st_d = ST_STBY;
      else if (uv_flag)  st_d = ST_UVP;
      else if (!smute_q) st_d = ST_SMUTE;
      else if (zm_flag)  st_d = ST_ZMUTE;
      else               st_d = ST_PLAY;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st_q <= ST_RST;
      else        st_q <= st_d;

   assign state_o   = st_q;
   assign dac_rst_o = (st_q == ST_RST);
   assign stby_o    = (st_q == ST_STBY);
   assign amute_o   = (st_q != ST_PLAY);
endmodule

// File: rtl/dac_mute_seq_chk.sv
module dac_mute_seq_chk #(
   parameter int unsigned DW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sup_q,
   input logic          por_done,
   input logic          stby_q,
   input logic          uv_flag,
   input logic          zm_flag,
   input logic          any_halt,
   input logic          frame_stb_i,
   input logic [DW-1:0] smp_l_i,
   input logic [DW-1:0] smp_r_i,
   input logic          dac_rst_o,
   input logic [2:0]    state_o
);
   a_r1_no_supply_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_q |=> dac_rst_o);

   a_r2_reset_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sup_q) |=> dac_rst_o);

   a_r4_nonzero_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb_i && ((|smp_l_i) || (|smp_r_i))) |=> !zm_flag);

   a_r5_uv_reported: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_flag && por_done && !stby_q) |=> (state_o == 3'd3));

   a_r6_halt_to_stby: assert property (@(posedge clk) disable iff (!rst_n)
      any_halt |=> stby_q);

   a_r8_stby_over_mutes: assert property (@(posedge clk) disable iff (!rst_n)
      (stby_q && por_done) |=> (state_o == 3'd4));
endmodule

bind dac_mute_seq dac_mute_seq_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sup_q(sup_q), .por_done(por_done),
   .stby_q(stby_q), .uv_flag(uv_flag), .zm_flag(zm_flag), .any_halt(any_halt),
   .frame_stb_i(frame_stb_i), .smp_l_i(smp_l_i), .smp_r_i(smp_r_i),
   .dac_rst_o(dac_rst_o), .state_o(state_o));

// File: tb/dac_mute_seq_tb.sv
module dac_mute_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW         = 24;
   localparam int TDIV       = 10;
   localparam int PORT       = 4;
   localparam int UVT        = 6;
   localparam int ZRUN       = 16;
   localparam int HALT       = 200;
   localparam int RESF       = 4;
   localparam int FRAME      = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          supply_ok = 1'b0;
   logic          smute_n = 1'b1;
   logic          mclk = 1'b0, bclk = 1'b0, lrclk = 1'b0;
   logic          en_m = 1'b1, en_b = 1'b1, en_l = 1'b1;
   logic          stb = 1'b0;
   logic [DW-1:0] sl = '0, sr = '0;
   logic          dac_rst, amute, stby;
   logic [2:0]    state;
   logic [7:0]    ph = '0;

   int n_chk = 0;
   int n_fail = 0;
   int zcnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      ph <= ph + 8'd1;
      if (en_m) mclk  <= ph[1];
      if (en_b) bclk  <= ph[2];
      if (en_l) lrclk <= ph[6];
   end

   dac_mute_seq #(
      .DW(DW), .TICK_DIV(TDIV), .POR_TICKS(PORT), .UV_TICKS(UVT),
      .ZERO_RUN(ZRUN), .HALT_CYC(HALT), .RESUME_FRAMES(RESF), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .smute_n_i(smute_n),
      .mclk_i(mclk), .bclk_i(bclk), .lrclk_i(lrclk), .frame_stb_i(stb),
      .smp_l_i(sl), .smp_r_i(sr), .dac_rst_o(dac_rst), .amute_o(amute),
      .stby_o(stby), .state_o(state));

   function automatic logic [2:0] prio(bit por, bit sb, bit uv, bit sm, bit zm);
      if (!por)    return 3'd5;
      else if (sb) return 3'd4;
      else if (uv) return 3'd3;
      else if (sm) return 3'd2;
      else if (zm) return 3'd1;
      return 3'd0;
   endfunction

   task automatic check(input string req, input logic [2:0] exp);
      logic [5:0] act, want;
      act  = {state, dac_rst, amute, stby};
      want = {exp, exp == 3'd5, exp != 3'd0, exp == 3'd4};
      n_chk++;
      if (act !== want) begin
         n_fail++;
         $display("FAIL %s: {state,rst,mute,stby} actual %b expected %b", req, act, want);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic frame(input logic [DW-1:0] l, input logic [DW-1:0] r);
      @(negedge clk);
      stb = 1'b1; sl = l; sr = r;
      @(negedge clk);
      stb = 1'b0; sl = '0; sr = '0;
      if (l == '0 && r == '0) zcnt = (zcnt < ZRUN) ? zcnt + 1 : ZRUN;
      else                    zcnt = 0;
      wait_cyc(3);
   endtask

   function automatic logic [DW-1:0] rnd_word();
      logic [DW-1:0] w;
      w = DW'($urandom());
      if (w == '0) w = 1;
      return w;
   endfunction

   task automatic set_clk(input int idx, input bit on);
      if (idx == 0) en_m = on;
      else if (idx == 1) en_b = on;
      else en_l = on;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(5);
      check("R1 reset state without supply", prio(0, 0, 0, 0, 0));

      // R2 power-on hold
      supply_ok = 1'b1;
      wait_cyc((PORT - 1) * TDIV - 1);
      check("R2 still in reset before hold time", 3'd5);
      wait_cyc(2 * TDIV + 10);
      check("R2 R9 released to play", prio(1, 0, 0, 0, 0));

      // R3 zero run boundary
      for (int i = 0; i < ZRUN - 1; i++) frame('0, '0);
      check("R3 one short of run stays playing", prio(1, 0, 0, 0, zcnt >= ZRUN));
      frame('0, '0);
      check("R3 full zero run mutes", prio(1, 0, 0, 0, zcnt >= ZRUN));
      frame('0, 24'h000100);
      check("R4 right-channel nonzero releases", prio(1, 0, 0, 0, zcnt >= ZRUN));

      // R3 R4 random frame streams
      for (int i = 0; i < 120; i++) begin
         int sel;
         sel = $urandom_range(0, 19);
         if (sel < 17)       frame('0, '0);
         else if (sel == 17) frame(rnd_word(), '0);
         else if (sel == 18) frame('0, rnd_word());
         else                frame(rnd_word(), rnd_word());
         check("R3 R4 random frame stream", prio(1, 0, 0, 0, zcnt >= ZRUN));
      end

      // stack conditions: zero mute, soft mute, undervoltage, standby
      for (int i = 0; i < ZRUN; i++) frame('0, '0);
      check("R3 zero mute before soft mute", 3'd1);
      smute_n = 1'b0;
      wait_cyc(6);
      check("R5 R8 soft mute outranks zero mute", prio(1, 0, 0, 1, 1));
      wait_cyc((UVT - 1) * TDIV - 12);
      check("R5 undervoltage not yet", 3'd2);
      wait_cyc(2 * TDIV + 12);
      check("R5 long low enters undervoltage", prio(1, 0, 1, 1, 1));
      en_b = 1'b0;
      wait_cyc(HALT / 2);
      check("R6 short bit clock gap ignored", 3'd3);
      wait_cyc(HALT / 2 + 20);
      check("R6 R8 halt outranks undervoltage", prio(1, 1, 1, 1, 1));
      smute_n = 1'b1;
      wait_cyc(6);
      check("R8 standby persists after pin release", 3'd4);
      en_b = 1'b1;
      wait_cyc((RESF - 1) * FRAME - 20);
      check("R7 too few frames to resume", 3'd4);
      wait_cyc(3 * FRAME + 40);
      check("R7 R8 resume falls to zero mute", prio(1, 0, 0, 0, 1));
      frame(24'h800000, '0);
      check("R4 R9 negative sample back to play", 3'd0);

      // R6 R7 each clock in turn
      for (int c = 0; c < 3; c++) begin
         set_clk(c, 1'b0);
         wait_cyc(HALT + 20);
         check("R6 clock halt gives standby", 3'd4);
         set_clk(c, 1'b1);
         wait_cyc((RESF - 1) * FRAME - 20);
         check("R7 resume waits for frames", 3'd4);
         wait_cyc(3 * FRAME + 40);
         check("R7 resume to play", 3'd0);
      end

      // R1 R8 supply loss outranks standby
      en_l = 1'b0;
      wait_cyc(HALT + 20);
      supply_ok = 1'b0;
      wait_cyc(5);
      check("R1 R8 supply loss outranks standby", 3'd5);
      en_l = 1'b1;
      supply_ok = 1'b1;
      wait_cyc((PORT + 1) * TDIV + 10 + 6 * FRAME);
      check("R2 R9 second power-up plays", 3'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule